// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small programmable logic device. It takes the sum-of-products result for its output from the OR array. A static configuration word sets four things: whether that result goes straight to the pin or through a D register, whether the pin is active-high or active-low, what is fed back to the array, and which clock the register uses. An output-enable product term is built inside the cell from an input vector and a fuse mask, and it decides when the pad is driven.

The cell runs on a free-running system clock `sys_clk`. The register's own clock, either the clock pin or a product-term clock, true or complemented, is treated as a data signal. A rising transition of the selected and optionally inverted source is detected on `sys_clk` and makes the register capture. The clear term acts on the outputs in the same cycle it is raised, with no edge needed. The preset term only acts at a capture event. Configuration inputs are meant to change only while `sys_rst` is high.

Top module: `pld_out_cell`

## Requirements
- R1: With `cfg_reg`=0 and `cfg_pol`=1, `pin_out` equals `sop_in` combinationally, with no clock involved.
- R2: With `cfg_reg`=1, the register loads `sop_in` on a rising edge of the selected clock. The new value appears on `fb_out` and `pin_out` on the `sys_clk` edge that first sees the raised clock level.
- R3: If `preset_in` is 1 at a capture event and `clear_in` is 0, the register becomes 1 whatever `sop_in` is.
- R4: While `clear_in` is 1, the register value seen at the outputs is 0 in the same cycle, without any clock edge. The stored value is 0 after the clear is released.
- R5: If `preset_in` and `clear_in` are both 1, clear wins and the register is 0.
- R6: `cfg_pol`=1 passes the selected data to `pin_out` unchanged. `cfg_pol`=0 inverts it. This holds in both the combinatorial and the registered mode.
- R7: `pin_oe` is the AND, over every input i, of (`oe_vec[i]` OR `oe_fuse[2i]`) and (NOT `oe_vec[i]` OR `oe_fuse[2i+1]`). A fuse bit of 1 means the connection is open: bit 2i is the true literal and bit 2i+1 is the complemented literal.
- R8: With every fuse bit at 1, `pin_oe` is always 1 (dedicated output). With every fuse bit at 0, `pin_oe` is always 0 (dedicated input).
- R9: With `cfg_reg`=1, `fb_out` is the true register value, taken before the polarity stage. With `cfg_reg`=0, `fb_out` follows `pin_in`.
- R10: `cfg_clk[1]` selects the clock source (0 = clock pin, 1 = product-term clock). `cfg_clk[0]`=1 inverts it, so capture happens on the falling edge of the raw source. The unselected source has no effect.
- R11: With no capture event and no clear, the register holds its value, including across a falling edge of a non-inverted source.
- R12: `sys_rst` (synchronous, active-high) sets the register to 0. No capture event is seen in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System sampling clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| clk_pin | input | 1 | Dedicated clock pin level |
| clk_term | input | 1 | Product-term clock level |
| cfg_reg | input | 1 | 1 = registered, 0 = combinatorial |
| cfg_pol | input | 1 | 1 = active-high, 0 = active-low |
| cfg_clk | input | 2 | {source, invert} clock select |
| sop_in | input | 1 | OR-array sum term |
| preset_in | input | 1 | Global synchronous preset term |
| clear_in | input | 1 | Global asynchronous clear term |
| oe_vec | input | OE_INPUTS | Inputs to the output-enable term |
| oe_fuse | input | 2*OE_INPUTS | Output-enable fuse mask, 1 = open |
| pin_in | input | 1 | Level read back from the pad |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
Preset and clear can both be true at the capture event itself. The bench raises both before a rising clock-pin edge and expects 0 through the edge and after both are dropped. Clear is also raised while the register holds 1, and the outputs are sampled before any further `sys_clk` edge to show it acts in the same cycle. Separately, the inverted clock mode is judged by seeing no capture on the raw rise and a capture on the raw fall.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  localparam int CLK_SRC_BIT = 1;
  localparam int CLK_INV_BIT = 0;
  localparam int CLK_SEL_W   = 2;

  typedef enum logic {
    SRC_PIN  = 1'b0,
    SRC_TERM = 1'b1
  } clk_src_e;

  function automatic logic apply_polarity(input logic d, input logic active_high);
    return active_high ? d : ~d;
  endfunction
endpackage

// File: rtl/pld_oe_term.sv
module pld_oe_term #(
  parameter int N_IN = 8,
  localparam int FUSE_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]   term_in,
  input  logic [FUSE_W-1:0] fuse_open,
  output logic              term_true
);
  logic [N_IN-1:0] lit_ok;

  // Each input contributes a true literal (fuse 2i) and a complement literal (fuse 2i+1).
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_ok[i] = (term_in[i] | fuse_open[2*i]) & (~term_in[i] | fuse_open[2*i+1]);
  end

  assign term_true = &lit_ok;
endmodule

// File: rtl/pld_clk_pick.sv
module pld_clk_pick
  import pld_cell_pkg::*;
(
  input  logic                 sys_clk,
  input  logic                 sys_rst,
  input  logic                 clk_pin,
  input  logic                 clk_term,
  input  logic [CLK_SEL_W-1:0] clk_sel,
  output logic                 cap_edge
);
  logic raw_src;
  logic sel_lvl;
  logic sel_prev;

  always_comb begin
    raw_src = (clk_src_e'(clk_sel[CLK_SRC_BIT]) == SRC_TERM) ? clk_term : clk_pin;
    sel_lvl = raw_src ^ clk_sel[CLK_INV_BIT];
  end

  // prev held high in reset so no edge is reported right after reset
  always_ff @(posedge sys_clk) begin
    if (sys_rst) sel_prev <= 1'b1;
    else         sel_prev <= sel_lvl;
  end

  assign cap_edge = sel_lvl & ~sel_prev;
endmodule

// File: rtl/pld_dreg.sv
module pld_dreg (
  input  logic sys_clk,
  input  logic sys_rst,
  input  logic cap_edge,
  input  logic d_in,
  input  logic preset_in,
  input  logic clear_in,
  output logic q_out
);
  logic q_r;

  always_ff @(posedge sys_clk) begin
    if (sys_rst)       q_r <= 1'b0;
    else if (clear_in) q_r <= 1'b0;
    else if (cap_edge) q_r <= preset_in ? 1'b1 : d_in;
  end

  // clear masks the stored value at once, before the next sys_clk edge
  assign q_out = q_r & ~clear_in;
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int OE_INPUTS = 8
) (
  input  logic                   sys_clk,
  input  logic                   sys_rst,
  input  logic                   clk_pin,
  input  logic                   clk_term,
  input  logic                   cfg_reg,
  input  logic                   cfg_pol,
  input  logic [1:0]             cfg_clk,
  input  logic                   sop_in,
  input  logic                   preset_in,
  input  logic                   clear_in,
  input  logic [OE_INPUTS-1:0]   oe_vec,
  input  logic [2*OE_INPUTS-1:0] oe_fuse,
  input  logic                   pin_in,
  output logic                   pin_out,
  output logic                   pin_oe,
  output logic                   fb_out
);
  logic cap_edge;
  logic q_val;
  logic data_sel;

  pld_clk_pick u_clk (
    .sys_clk  (sys_clk),
    .sys_rst  (sys_rst),
    .clk_pin  (clk_pin),
    .clk_term (clk_term),
    .clk_sel  (cfg_clk),
    .cap_edge (cap_edge)
  );

  pld_dreg u_reg (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .cap_edge  (cap_edge),
    .d_in      (sop_in),
    .preset_in (preset_in),
    .clear_in  (clear_in),
    .q_out     (q_val)
  );

  pld_oe_term #(.N_IN(OE_INPUTS)) u_oe (
    .term_in   (oe_vec),
    .fuse_open (oe_fuse),
    .term_true (pin_oe)
  );

  always_comb begin
    data_sel = cfg_reg ? q_val : sop_in;
    pin_out  = apply_polarity(data_sel, cfg_pol);
    fb_out   = cfg_reg ? q_val : pin_in;
  end
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
  parameter int OE_INPUTS = 8
) (
  input logic                   sys_clk,
  input logic                   sys_rst,
  input logic                   cfg_reg,
  input logic                   cfg_pol,
  input logic                   sop_in,
  input logic                   preset_in,
  input logic                   clear_in,
  input logic [2*OE_INPUTS-1:0] oe_fuse,
  input logic                   pin_in,
  input logic                   pin_out,
  input logic                   pin_oe,
  input logic                   fb_out,
  input logic                   cap_edge
);
  // R1
  comb_pass_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (!cfg_reg && cfg_pol) |-> (pin_out == sop_in));
  // R3
  preset_set_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (cfg_reg && cap_edge && preset_in && !clear_in) |=> (!cfg_reg || clear_in || fb_out));
  // R4
  clear_now_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (cfg_reg && clear_in) |-> !fb_out);
  // R5
  clear_wins_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (cfg_reg && clear_in && preset_in && cap_edge) |=> (!cfg_reg || !fb_out));
  // R8
  oe_open_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (&oe_fuse) |-> pin_oe);
  // R8
  oe_intact_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (oe_fuse == '0) |-> !pin_oe);
  // R9
  fb_pin_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !cfg_reg |-> (fb_out == pin_in));
  // R11
  hold_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (cfg_reg && !cap_edge && !clear_in) |=> (!cfg_reg || clear_in || $stable(fb_out)));
endmodule

bind pld_out_cell pld_out_cell_chk #(.OE_INPUTS(OE_INPUTS)) u_chk (
  .sys_clk   (sys_clk),
  .sys_rst   (sys_rst),
  .cfg_reg   (cfg_reg),
  .cfg_pol   (cfg_pol),
  .sop_in    (sop_in),
  .preset_in (preset_in),
  .clear_in  (clear_in),
  .oe_fuse   (oe_fuse),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .fb_out    (fb_out),
  .cap_edge  (cap_edge)
);

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 4;

  logic sys_clk = 1'b0;
  logic sys_rst = 1'b1;
  logic clk_pin = 1'b0, clk_term = 1'b0;
  logic cfg_reg = 1'b1, cfg_pol = 1'b1;
  logic [1:0] cfg_clk = 2'b00;
  logic sop_in = 1'b0, preset_in = 1'b0, clear_in = 1'b0;
  logic [NIN-1:0] oe_vec = '0;
  logic [2*NIN-1:0] oe_fuse = '1;
  logic pin_in = 1'b0;
  logic pin_out, pin_oe, fb_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  pld_out_cell #(.OE_INPUTS(NIN)) dut_i (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .clk_pin(clk_pin), .clk_term(clk_term),
    .cfg_reg(cfg_reg), .cfg_pol(cfg_pol), .cfg_clk(cfg_clk), .sop_in(sop_in),
    .preset_in(preset_in), .clear_in(clear_in), .oe_vec(oe_vec), .oe_fuse(oe_fuse),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge sys_clk);
    #1;
  endtask

  task automatic restart(input logic reg_m, input logic pol, input logic [1:0] csel);
    sys_rst = 1'b1;
    cfg_reg = reg_m; cfg_pol = pol; cfg_clk = csel;
    clk_pin = 1'b0; clk_term = 1'b0; preset_in = 1'b0; clear_in = 1'b0;
    tick(); tick();
    sys_rst = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    restart(1'b1, 1'b1, 2'b00);
    chk("R12 fb after reset", fb_out, 1'b0);
    chk("R12 pin after reset", pin_out, 1'b0);
  endtask

  task automatic t_comb();
    restart(1'b0, 1'b1, 2'b00);
    sop_in = 1'b1; #1;
    chk("R1 comb high", pin_out, 1'b1);
    sop_in = 1'b0; #1;
    chk("R1 comb low", pin_out, 1'b0);
    cfg_pol = 1'b0; sop_in = 1'b1; #1;
    chk("R6 comb inverted", pin_out, 1'b0);
    pin_in = 1'b1; #1;
    chk("R9 comb fb from pin", fb_out, 1'b1);
    pin_in = 1'b0; #1;
    chk("R9 comb fb from pin low", fb_out, 1'b0);
  endtask

  task automatic t_reg_capture();
    restart(1'b1, 1'b1, 2'b00);
    sop_in = 1'b1; clk_pin = 1'b1; tick();
    chk("R2 capture 1", fb_out, 1'b1);
    chk("R2 pin after capture", pin_out, 1'b1);
    sop_in = 1'b0; clk_pin = 1'b0; tick();
    chk("R11 hold over falling edge", fb_out, 1'b1);
    tick();
    chk("R11 hold idle", fb_out, 1'b1);
    cfg_pol = 1'b0; #1;
    chk("R6 reg inverted pin", pin_out, 1'b0);
    chk("R9 reg fb is true Q", fb_out, 1'b1);
    cfg_pol = 1'b1;
    clk_pin = 1'b1; tick();
    chk("R2 capture 0", fb_out, 1'b0);
    clk_pin = 1'b0; tick();
  endtask

  task automatic t_preset_clear();
    restart(1'b1, 1'b1, 2'b00);
    sop_in = 1'b0; preset_in = 1'b1; clk_pin = 1'b1; tick();
    chk("R3 preset sets Q", fb_out, 1'b1);
    preset_in = 1'b0; clk_pin = 1'b0; tick();
    clear_in = 1'b1; #1;
    chk("R4 clear same cycle", fb_out, 1'b0);
    chk("R4 clear pin same cycle", pin_out, 1'b0);
    tick();
    clear_in = 1'b0; tick();
    chk("R4 stored 0 after clear", fb_out, 1'b0);
    sop_in = 1'b1; clk_pin = 1'b1; tick();
    clk_pin = 1'b0; tick();
    chk("R2 recapture 1", fb_out, 1'b1);
    preset_in = 1'b1; clear_in = 1'b1; tick();
    clk_pin = 1'b1; tick();
    chk("R5 clear beats preset", fb_out, 1'b0);
    preset_in = 1'b0; clear_in = 1'b0; clk_pin = 1'b0; sop_in = 1'b0; tick();
    chk("R5 stays 0 after release", fb_out, 1'b0);
  endtask

  task automatic t_clksel();
    restart(1'b1, 1'b1, 2'b10);
    sop_in = 1'b1; clk_pin = 1'b1; tick();
    clk_pin = 1'b0; tick();
    chk("R10 pin ignored with term source", fb_out, 1'b0);
    clk_term = 1'b1; tick();
    chk("R10 term source captures", fb_out, 1'b1);
    clk_term = 1'b0; tick();
    restart(1'b1, 1'b1, 2'b01);
    chk("R12 no edge after reset inverted", fb_out, 1'b0);
    sop_in = 1'b1; clk_pin = 1'b1; tick();
    chk("R10 inverted no capture on rise", fb_out, 1'b0);
    clk_pin = 1'b0; tick();
    chk("R10 inverted capture on fall", fb_out, 1'b1);
  endtask

  task automatic t_oe();
    oe_fuse = '1; oe_vec = 4'b1010; #1;
    chk("R8 all open", pin_oe, 1'b1);
    oe_vec = 4'b0101; #1;
    chk("R8 all open other vec", pin_oe, 1'b1);
    oe_fuse = '0; oe_vec = 4'b1111; #1;
    chk("R8 all intact", pin_oe, 1'b0);
    oe_vec = 4'b0000; #1;
    chk("R8 all intact zeros", pin_oe, 1'b0);
    // needs in[0]=1 (true lit) and in[2]=0 (complement lit)
    oe_fuse = 8'b11_01_11_10;
    oe_vec = 4'b1011; #1;
    chk("R7 term true", pin_oe, 1'b1);
    oe_vec = 4'b0101; #1;
    chk("R7 in2 high blocks", pin_oe, 1'b0);
    oe_vec = 4'b1010; #1;
    chk("R7 in0 low blocks", pin_oe, 1'b0);
    oe_fuse = '1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_comb();
    t_reg_capture();
    t_preset_clear();
    t_clksel();
    t_oe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule